// File: doc/BRIEF.md
# Dual-Channel DMA Controller

This block moves blocks of words between peripheral devices and memory without processor involvement once a transfer is launched. It holds two channels, each with its own programming registers, and each can run at the same time as the other as though it were a separate engine. Software sets a channel's starting word address and its word count. It then writes a control word that picks the direction (device into memory, or memory out to the device) and the bus usage style, and launches the transfer. When the block finishes, the channel raises its own interrupt line.

On the device side each channel has a ready/valid stream in each direction. On the memory side a single shared request/grant port carries one word per granted cycle, and memory answers reads in the same cycle. A channel in cycle-stealing style gives the bus up after every word. A channel in burst style keeps the bus locked until its block completes. When both channels compete for an unlocked bus, the lower-numbered channel wins.

Top module: `dma_ctrl`

## Requirements
- R1: Writing select 0 stores a channel's word address and select 1 stores its word count. While the channel is idle, both can be read back unchanged through the same selects on the read port.
- R2: A channel leaves idle only on a control write (select 2) with bit 0 (start) set. After reset and before any start, the memory request stays low and all interrupts are low.
- R3: Each granted word moves exactly one word. The memory address equals the channel's current address. Afterwards the address rises by one and the remaining count falls by one. Device-to-memory writes the device word; memory-to-device (control bit 1 set) delivers the memory read word to the device.
- R4: When the count reaches zero the channel goes idle, and its interrupt and done flag (status bit 1) go high. They stay high until a control write with bit 4 set, or a new start.
- R5: A start with a count of zero sets done and the interrupt on the next cycle and issues no bus request.
- R6: In cycle-stealing mode (control bit 2 clear), a channel never moves words in two consecutive cycles. After each word it drops its request for at least one cycle.
- R7: In burst mode (control bit 2 set), with the device always ready and grant always given, the words of a block move in consecutive cycles. Once the channel has moved its first word it holds the bus lock, and the other channel moves no word until the block is done.
- R8: When neither channel holds the lock and both request, channel 0 is served first.
- R9: While a channel is busy, writes to its address, count and control are ignored, except control bit 3 (abort). Abort ends the channel after any word in progress in that cycle and sets done. The remaining count plus the words moved equals the programmed count.
- R10: Each channel drives only its own interrupt bit; the other channel's interrupt is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_ch | input | CHW | Channel addressed by the write |
| reg_wr_sel | input | 2 | 0 address, 1 count, 2 control |
| reg_wr_data | input | DW | Write data; control bits 0 start, 1 memory-to-device, 2 burst, 3 abort, 4 clear done |
| reg_rd_ch | input | CHW | Channel addressed by the read |
| reg_rd_sel | input | 2 | 0 address, 1 count, 2 status |
| reg_rd_data | output | DW | Read data; status bits 0 busy, 1 done, 2 memory-to-device, 3 burst |
| irq | output | NCH | Per-channel completion interrupt |
| mem_req | output | 1 | Memory bus request |
| mem_gnt | input | 1 | Memory bus grant, one word per granted cycle |
| mem_lock | output | 1 | Bus held by a burst channel |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the grant cycle |
| dev_in_valid | input | NCH | Device word available, per channel |
| dev_in_ready | output | NCH | Device word taken, per channel |
| dev_in_data | input | NCH*DW | Device words, channel c at bits c*DW |
| dev_out_valid | output | NCH | Word delivered to device, per channel |
| dev_out_ready | input | NCH | Device can accept, per channel |
| dev_out_data | output | NCH*DW | Words to devices, channel c at bits c*DW |

## Verification
The sweep covers every channel, direction and bus style at block lengths of one, three and seven words. A one-word block catches an off-by-one in the count test that would run one extra or one short word. The zero-count start must finish at once; a design that decremented first would wrap the count and run 256 words. The bench checks cycle-stealing spacing and burst back-to-back timing, so a mode swap shows as either touching or spaced words. A burst started before a competing channel must not be pre-empted, and simultaneous requests must go to channel 0 first. Writes to a busy channel must leave address and count untouched, while an abort mid-block must leave the remaining count consistent with the words already moved.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_SPARE = 2'd3
    } dma_sel_e;

    // control word bit positions
    localparam int CTL_START = 0;
    localparam int CTL_M2D   = 1;
    localparam int CTL_BURST = 2;
    localparam int CTL_ABORT = 3;
    localparam int CTL_CLEAR = 4;

    // status word bit positions
    localparam int STS_BUSY  = 0;
    localparam int STS_DONE  = 1;
    localparam int STS_M2D   = 2;
    localparam int STS_BURST = 3;

endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          in_valid_i,
    input  logic          out_ready_i,
    input  logic          xfer_i,
    output logic          want_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          m2d_o,
    output logic          burst_o,
    output logic [AW-1:0] addr_o,
    output logic [NW-1:0] cnt_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [NW-1:0] cnt;
        logic          m2d;
        logic          burst;
        logic          busy;
        logic          done;
        logic          gap;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     ctl_wr;
    logic     unused_bits;

    assign ctl_wr      = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign unused_bits = ^wr_data_i;

    always_comb begin
        st_d     = st_q;
        st_d.gap = 1'b0;
        if (st_q.busy) begin
            if (xfer_i) begin
                st_d.addr = st_q.addr + AW'(1);
                st_d.cnt  = st_q.cnt - NW'(1);
                st_d.gap  = ~st_q.burst;
                if (st_q.cnt == NW'(1)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
            if (ctl_wr && wr_data_i[CTL_ABORT]) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (wr_en_i) begin
            case (wr_sel_i)
                SEL_ADDR:  st_d.addr = wr_data_i[AW-1:0];
                SEL_COUNT: st_d.cnt  = wr_data_i[NW-1:0];
                SEL_CTRL: begin
                    st_d.m2d   = wr_data_i[CTL_M2D];
                    st_d.burst = wr_data_i[CTL_BURST];
                    if (wr_data_i[CTL_CLEAR]) st_d.done = 1'b0;
                    if (wr_data_i[CTL_START]) begin
                        if (st_q.cnt == '0) begin
                            st_d.done = 1'b1;
                        end else begin
                            st_d.done = 1'b0;
                            st_d.busy = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign want_o  = st_q.busy && !st_q.gap && (st_q.m2d ? out_ready_i : in_valid_i);
    assign busy_o  = st_q.busy;
    assign done_o  = st_q.done;
    assign m2d_o   = st_q.m2d;
    assign burst_o = st_q.burst;
    assign addr_o  = st_q.addr;
    assign cnt_o   = st_q.cnt;

    assert_start_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(ctl_wr && wr_data_i[CTL_START]));

    assert_xfer_needs_want_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |-> want_o);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> (st_q.cnt == $past(st_q.cnt) - NW'(1)) && (st_q.addr == $past(st_q.addr) + AW'(1)));

    assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && !(ctl_wr && (wr_data_i[CTL_CLEAR] || wr_data_i[CTL_START])) |=> st_q.done);

    assert_steal_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i && !st_q.burst |=> !want_o);

    assert_busy_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && !xfer_i |=> $stable(st_q.cnt) && $stable(st_q.addr));

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
    parameter int NCH = 2,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] want_i,
    input  logic [NCH-1:0] burst_i,
    input  logic [NCH-1:0] busy_i,
    input  logic           gnt_i,
    output logic           req_o,
    output logic [CHW-1:0] sel_o,
    output logic [NCH-1:0] xfer_o,
    output logic           lock_o
);

    typedef struct packed {
        logic           lock;
        logic [CHW-1:0] owner;
    } arb_st_t;

    arb_st_t st_d, st_q;

    // pick: locked owner, else lowest index wins
    always_comb begin
        req_o = 1'b0;
        sel_o = st_q.owner;
        if (st_q.lock) begin
            req_o = want_i[st_q.owner];
        end else begin
            for (int i = NCH - 1; i >= 0; i--) begin
                if (want_i[i]) begin
                    req_o = 1'b1;
                    sel_o = CHW'(i);
                end
            end
        end
        for (int i = 0; i < NCH; i++) begin
            xfer_o[i] = req_o && gnt_i && (sel_o == CHW'(i));
        end
    end

    always_comb begin
        st_d = st_q;
        if (st_q.lock) begin
            if (!busy_i[st_q.owner]) st_d.lock = 1'b0;
        end else if (req_o && gnt_i && burst_i[sel_o]) begin
            st_d.lock  = 1'b1;
            st_d.owner = sel_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.lock;

    assert_one_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xfer_o));

    assert_low_index_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !st_q.lock && want_i[0] |-> sel_o == '0);

    assert_lock_owner_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock && req_o |-> sel_o == st_q.owner);

    assert_lock_after_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.lock && req_o && gnt_i && burst_i[sel_o] |=> st_q.lock);

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int NW  = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [CHW-1:0]     reg_wr_ch,
    input  logic [1:0]         reg_wr_sel,
    input  logic [DW-1:0]      reg_wr_data,
    input  logic [CHW-1:0]     reg_rd_ch,
    input  logic [1:0]         reg_rd_sel,
    output logic [DW-1:0]      reg_rd_data,
    output logic [NCH-1:0]     irq,
    output logic               mem_req,
    input  logic               mem_gnt,
    output logic               mem_lock,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    input  logic [NCH-1:0]     dev_in_valid,
    output logic [NCH-1:0]     dev_in_ready,
    input  logic [NCH*DW-1:0]  dev_in_data,
    output logic [NCH-1:0]     dev_out_valid,
    input  logic [NCH-1:0]     dev_out_ready,
    output logic [NCH*DW-1:0]  dev_out_data
);

    logic [NCH-1:0] want, busy, done, m2d, burst, xfer;
    logic [CHW-1:0] sel;
    logic [AW-1:0]  addr_a [NCH];
    logic [NW-1:0]  cnt_a  [NCH];
    logic [DW-1:0]  din_a  [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dma_chan #(.AW(AW), .DW(DW), .NW(NW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en_i    (reg_wr_en && (reg_wr_ch == CHW'(g))),
            .wr_sel_i   (reg_wr_sel),
            .wr_data_i  (reg_wr_data),
            .in_valid_i (dev_in_valid[g]),
            .out_ready_i(dev_out_ready[g]),
            .xfer_i     (xfer[g]),
            .want_o     (want[g]),
            .busy_o     (busy[g]),
            .done_o     (done[g]),
            .m2d_o      (m2d[g]),
            .burst_o    (burst[g]),
            .addr_o     (addr_a[g]),
            .cnt_o      (cnt_a[g])
        );
        assign din_a[g]                = dev_in_data[g*DW +: DW];
        assign dev_in_ready[g]         = xfer[g] && !m2d[g];
        assign dev_out_valid[g]        = xfer[g] && m2d[g];
        assign dev_out_data[g*DW +: DW] = mem_rdata;
        assign irq[g]                  = done[g];
    end

    dma_arb #(.NCH(NCH)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .want_i (want),
        .burst_i(burst),
        .busy_i (busy),
        .gnt_i  (mem_gnt),
        .req_o  (mem_req),
        .sel_o  (sel),
        .xfer_o (xfer),
        .lock_o (mem_lock)
    );

    assign mem_addr  = addr_a[sel];
    assign mem_we    = !m2d[sel];
    assign mem_wdata = din_a[sel];

    always_comb begin
        reg_rd_data = '0;
        case (reg_rd_sel)
            SEL_ADDR:  reg_rd_data[AW-1:0] = addr_a[reg_rd_ch];
            SEL_COUNT: reg_rd_data[NW-1:0] = cnt_a[reg_rd_ch];
            SEL_CTRL: begin
                reg_rd_data[STS_BUSY]  = busy[reg_rd_ch];
                reg_rd_data[STS_DONE]  = done[reg_rd_ch];
                reg_rd_data[STS_M2D]   = m2d[reg_rd_ch];
                reg_rd_data[STS_BURST] = burst[reg_rd_ch];
            end
            default: ;
        endcase
    end

    assert_single_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt |-> $countones({dev_in_ready, dev_out_valid}) == 1);

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy == '0 |-> !mem_req);

endmodule

// File: tb/dma_ctrl_tb.sv
`timescale 1ns/1ps
module dma_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [0:0]  reg_wr_ch = '0;
    logic [1:0]  reg_wr_sel = '0;
    logic [15:0] reg_wr_data = '0;
    logic [0:0]  reg_rd_ch = '0;
    logic [1:0]  reg_rd_sel = '0;
    logic [15:0] reg_rd_data;
    logic [1:0]  irq;
    logic        mem_req, mem_gnt, mem_lock, mem_we;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [1:0]  dev_in_valid = 2'b11;
    logic [1:0]  dev_in_ready;
    logic [31:0] dev_in_data;
    logic [1:0]  dev_out_valid;
    logic [1:0]  dev_out_ready = 2'b11;
    logic [31:0] dev_out_data;
    logic        gnt_en = 1'b1;

    always #2.5 clk = ~clk;

    dma_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_ch(reg_wr_ch), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_ch(reg_rd_ch), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .irq(irq),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_lock(mem_lock), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data),
        .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data)
    );

    // memory model: grant gated by bench, reads return a function of the address
    logic [15:0] wmem [256];
    assign mem_gnt   = mem_req & gnt_en;
    assign mem_rdata = 16'hC000 | {8'h00, mem_addr};
    always @(posedge clk) if (mem_req && mem_gnt && mem_we) wmem[mem_addr] <= mem_wdata;

    // device sources: word = tag per channel + running pop count
    logic [7:0] pop_q [2];
    for (genvar g = 0; g < 2; g++) begin : g_src
        assign dev_in_data[g*16 +: 16] = 16'hA000 + 16'(g * 256) + {8'h00, pop_q[g]};
        always @(posedge clk) begin
            if (!rst_n) pop_q[g] <= '0;
            else if (dev_in_ready[g] && dev_in_valid[g]) pop_q[g] <= pop_q[g] + 8'd1;
        end
    end

    // monitor statistics, sampled late in each cycle
    int          cyc = 0;
    int          xcnt [2];
    int          first_cyc [2];
    int          last_cyc [2];
    int          steal_viol [2];
    bit          prev_x [2];
    int          req_cycles = 0;
    logic [15:0] rx [2][16];
    bit          stat_clr = 1'b0;
    bit          run_burst [2];

    always @(negedge clk) begin
        #2;
        for (int c = 0; c < 2; c++) begin
            bit x;
            x = (dev_in_ready[c] && dev_in_valid[c]) || (dev_out_valid[c] && dev_out_ready[c]);
            if (stat_clr) begin
                xcnt[c] = 0; first_cyc[c] = 0; last_cyc[c] = 0; steal_viol[c] = 0;
            end else if (x) begin
                if (xcnt[c] == 0) first_cyc[c] = cyc;
                last_cyc[c] = cyc;
                if (dev_out_valid[c] && xcnt[c] < 16) rx[c][xcnt[c]] = dev_out_data[c*16 +: 16];
                if (prev_x[c] && !run_burst[c]) steal_viol[c]++;
                xcnt[c]++;
            end
            prev_x[c] = x;
        end
        if (stat_clr) req_cycles = 0;
        else if (mem_req) req_cycles++;
        cyc++;
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(int c, int sel, logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_ch = 1'(c); reg_wr_sel = 2'(sel); reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(int c, int sel, output logic [15:0] d);
        reg_rd_ch = 1'(c); reg_rd_sel = 2'(sel);
        #0.1;
        d = reg_rd_data;
    endtask

    task automatic clear_stats();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    task automatic wait_irq(int c);
        int t = 0;
        while (!irq[c] && t < 400) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_one(int c, int m2d, int bst, int base, int n);
        logic [15:0] v;
        logic [7:0]  p0;
        wr(c, 0, 16'(base));
        wr(c, 1, 16'(n));
        p0 = pop_q[c];
        run_burst[c] = (bst != 0);
        clear_stats();
        wr(c, 2, 16'(1 | (m2d << 1) | (bst << 2)));
        wait_irq(c);
        chk("R4 irq at end", 32'(irq[c]), 1);
        chk("R3 words moved", xcnt[c], n);
        rd(c, 0, v); chk("R3 final address", v, 32'(base + n));
        rd(c, 1, v); chk("R3 final count", v, 0);
        rd(c, 2, v); chk("R4 status done idle", 32'(v[1:0]), 2);
        if (bst != 0) chk("R7 back-to-back span", last_cyc[c] - first_cyc[c], n - 1);
        else          chk("R6 no touching words", steal_viol[c], 0);
        for (int i = 0; i < n; i++) begin
            if (m2d != 0) chk("R3 read word to device", rx[c][i], 32'(16'hC000 | 16'(base + i)));
            else          chk("R3 device word in memory", wmem[base + i],
                              32'(16'hA000 + 16'(c * 256) + {8'h00, 8'(p0 + 8'(i))}));
        end
        chk("R10 other irq quiet", 32'(irq[1 - c]), 0);
        repeat (3) @(negedge clk);
        chk("R4 irq held", 32'(irq[c]), 1);
        wr(c, 2, 16'h0010);
        chk("R4 irq cleared", 32'(irq[c]), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int k;
        run_burst[0] = 1'b0; run_burst[1] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // reset state
        chk("R2 irq after reset", 32'(irq), 0);
        chk("R2 no request after reset", 32'(mem_req), 0);
        rd(0, 2, v); chk("R2 ch0 status reset", v, 0);
        rd(1, 2, v); chk("R2 ch1 status reset", v, 0);

        // programming without start
        wr(0, 0, 16'h0010);
        wr(0, 1, 16'h0004);
        rd(0, 0, v); chk("R1 address readback", v, 16'h0010);
        rd(0, 1, v); chk("R1 count readback", v, 16'h0004);
        repeat (3) @(negedge clk);
        chk("R2 no request before start", 32'(mem_req), 0);

        // sweep channels, directions, modes, lengths
        for (int c = 0; c < 2; c++)
            for (int d = 0; d < 2; d++)
                for (int b = 0; b < 2; b++)
                    for (int ni = 0; ni < 3; ni++)
                        run_one(c, d, b, c * 128 + d * 64 + b * 32 + ni * 8,
                                (ni == 0) ? 1 : ((ni == 1) ? 3 : 7));

        // zero-count start
        wr(1, 1, 16'h0000);
        clear_stats();
        wr(1, 2, 16'h0001);
        chk("R5 done at once", 32'(irq[1]), 1);
        repeat (4) @(negedge clk);
        chk("R5 no bus request", req_cycles, 0);
        rd(1, 2, v); chk("R5 idle with done", 32'(v[1:0]), 2);
        wr(1, 2, 16'h0010);

        // fixed priority
        gnt_en = 1'b0;
        run_burst[0] = 1'b0; run_burst[1] = 1'b0;
        wr(0, 0, 16'h0080); wr(0, 1, 16'h0002);
        wr(1, 0, 16'h0090); wr(1, 1, 16'h0002);
        clear_stats();
        wr(1, 2, 16'h0001);
        wr(0, 2, 16'h0001);
        chk("R8 channel 0 presented first", 32'(mem_addr), 32'h80);
        gnt_en = 1'b1;
        wait_irq(0); wait_irq(1);
        chk("R8 channel 0 served first", 32'(first_cyc[0] < first_cyc[1]), 1);
        chk("R10 both channels done", 32'(irq), 3);
        wr(0, 2, 16'h0010); wr(1, 2, 16'h0010);

        // burst lock against a later request
        run_burst[1] = 1'b1; run_burst[0] = 1'b0;
        wr(1, 0, 16'h00A0); wr(1, 1, 16'h0006);
        wr(0, 0, 16'h00B0); wr(0, 1, 16'h0002);
        clear_stats();
        wr(1, 2, 16'h0004 | 16'h0001);
        wr(0, 2, 16'h0001);
        wait_irq(1); wait_irq(0);
        chk("R7 burst words", xcnt[1], 6);
        chk("R7 burst contiguous", last_cyc[1] - first_cyc[1], 5);
        chk("R7 no intrusion during burst", 32'(first_cyc[0] > last_cyc[1]), 1);
        chk("R7 waiting channel completes", xcnt[0], 2);
        wr(0, 2, 16'h0010); wr(1, 2, 16'h0010);
        run_burst[1] = 1'b0;

        // writes to a busy channel are ignored; abort with no word in flight
        gnt_en = 1'b0;
        wr(0, 0, 16'h0030); wr(0, 1, 16'h0004);
        clear_stats();
        wr(0, 2, 16'h0001);
        wr(0, 0, 16'h0055);
        wr(0, 1, 16'h0009);
        wr(0, 2, 16'h0016);
        rd(0, 0, v); chk("R9 address write ignored", v, 16'h0030);
        rd(0, 1, v); chk("R9 count write ignored", v, 16'h0004);
        rd(0, 2, v); chk("R9 control write ignored", v, 16'h0001);
        wr(0, 2, 16'h0008);
        rd(0, 2, v); chk("R9 abort stops with done", 32'(v[1:0]), 2);
        rd(0, 1, v); chk("R9 abort keeps count", v, 16'h0004);
        chk("R9 abort interrupt", 32'(irq[0]), 1);
        gnt_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 no words after abort", xcnt[0], 0);
        wr(0, 2, 16'h0010);

        // abort in the middle of a running block
        wr(0, 0, 16'h0060); wr(0, 1, 16'h000A);
        clear_stats();
        wr(0, 2, 16'h0001);
        repeat (3) @(negedge clk);
        wr(0, 2, 16'h0008);
        repeat (2) @(negedge clk);
        k = xcnt[0];
        rd(0, 1, v); chk("R9 count plus words", 32'(v) + 32'(k), 10);
        rd(0, 0, v); chk("R9 address after abort", v, 32'(16'h0060 + 16'(k)));
        repeat (5) @(negedge clk);
        chk("R9 stopped after abort", xcnt[0], k);
        wr(0, 2, 16'h0010);

        finish_run();
    end

endmodule